// File: doc/BRIEF.md
# Fixed-Point Arithmetic Self-Test Slice

This block exercises a small 18-bit fixed-point arithmetic unit against known answers. Two constant operands, fixed at elaboration, are applied in turn to add, subtract, multiply, divide and square root. Divide and square root run as iterative multi-cycle datapaths. The other three operations are combinational. For each operation, a controller captures the result, compares it with a golden value computed at elaboration, and updates one pass/fail indication and one completion indication for that operation.

The comparison is made twice, by two independent comparators fed with identical inputs. If the two comparators ever disagree, a separate flag is raised. This separates a fault in the checking logic from a fault in the arithmetic. The slice has no data inputs and is meant to be stamped out many times, with different operand parameters, to fill a device. It then runs at increasing clock rates until flags start to appear.

A per-operation fault-inject input flips the least significant bit of the captured result. This proves that the error path works.

Top module: `arith_selftest_slice`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, every completion flag, every error flag and the comparator-disagreement flag read 0.
- R2: The add operation produces (A + B) mod 2^18, and with correct arithmetic its error flag (bit 0 of both flag vectors) stays 0.
- R3: The subtract operation produces (A - B) mod 2^18, and with correct arithmetic its error flag (bit 1) stays 0.
- R4: The multiply operation produces the low 18 bits of the 36-bit product, and with correct arithmetic its error flag (bit 2) stays 0.
- R5: The divide operation (bit 3) produces floor(A / B) as an 18-bit quotient, and all ones when B is 0. With correct arithmetic its error flag stays 0.
- R6: The square-root operation (bit 4) produces floor(sqrt(A)) as a 9-bit root, zero-extended to 18 bits. With correct arithmetic its error flag stays 0.
- R7: A completion flag is set when its operation is first compared and then stays set until reset. The flags become set in the order add, subtract, multiply, divide, square root.
- R8: When fault-inject bit k is high, the captured result of operation k has its bit 0 inverted. Only error flag k then becomes set. It stays set after the inject bit returns low, until reset.
- R9: The comparator-disagreement flag stays 0 while both comparators see the same inputs, including when an injected error is present.
- R10: The controller cycles through the five operations without stopping, so an error injected after every operation has completed once is still detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inject_err | input | 5 | Per-operation fault inject: inverts bit 0 of the captured result |
| op_done | output | 5 | Sticky completion flag per operation (bit 0 add … bit 4 square root) |
| op_error | output | 5 | Sticky mismatch flag per operation |
| chk_disagree | output | 1 | Sticky flag: the two comparators gave different verdicts |

## Verification
Five slices are built with different operand pairs. One is an ordinary mid-range pair. One wraps the adder at full scale. A zero dividend gives zero results. A zero divisor takes the all-ones quotient path. Full-scale operands bring out the largest 9-bit root and a truncated product. Between them, these show whether wrap-around, truncation, the zero-divisor rule and the widest root are handled, rather than only typical values. A late fault injection on one operation tells per-operation flag isolation and stickiness apart from continuous looping. A reset in mid-run confirms that every flag clears.

// File: rtl/ast_pkg.sv
package ast_pkg;

    localparam int OPW     = 18;
    localparam int HALFW   = OPW / 2;
    localparam int NUM_OPS = 5;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_DIV  = 3'd3,
        OP_SQRT = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_LAUNCH = 2'd0,
        ST_WAIT   = 2'd1,
        ST_CHECK  = 2'd2
    } ctl_e;

    typedef struct packed {
        logic [OPW-1:0] value;
        logic           valid;
    } unit_res_t;

    // Golden model, evaluated at elaboration on constant operands.
    function automatic logic [OPW-1:0] golden(op_e op, logic [OPW-1:0] a, logic [OPW-1:0] b);
        logic [2*OPW-1:0] prod;
        int               root;
        prod = {{OPW{1'b0}}, a} * {{OPW{1'b0}}, b};
        root = 0;
        case (op)
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            OP_MUL:  return prod[OPW-1:0];
            OP_DIV:  return (b == '0) ? '1 : a / b;
            default: begin
                for (int k = 0; k < (1 << HALFW); k++)
                    if (k * k <= int'(a)) root = k;
                return OPW'(root);
            end
        endcase
    endfunction

endpackage

// File: rtl/ast_divider.sv
module ast_divider #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic         busy,
    output logic         valid
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    rem_q;
    logic [W-1:0]  quo_q, dsr_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    shifted;

    assign shifted  = {rem_q[W-1:0], quo_q[W-1]};
    assign quotient = quo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0; quo_q <= '0; dsr_q <= '0; cnt_q <= '0;
            busy  <= 1'b0; valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (start && !busy) begin
                if (divisor == '0) begin
                    quo_q <= '1;
                    valid <= 1'b1;
                end else begin
                    quo_q <= dividend;
                    rem_q <= '0;
                    dsr_q <= divisor;
                    cnt_q <= CW'(W);
                    busy  <= 1'b1;
                end
            end else if (busy) begin
                if (shifted >= {1'b0, dsr_q}) begin
                    rem_q <= shifted - {1'b0, dsr_q};
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted;
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy  <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end

    p_div_start_idle_r5: assert property (@(posedge clk) disable iff (rst) start |-> !busy);
    p_div_valid_free_r5: assert property (@(posedge clk) disable iff (rst) valid |-> !busy);
endmodule

// File: rtl/ast_sqrt.sv
module ast_sqrt #(
    parameter int W = 18
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   radicand,
    output logic [W/2-1:0] root,
    output logic           busy,
    output logic           valid
);
    localparam int HW = W / 2;
    localparam int CW = $clog2(HW + 1);

    logic [W-1:0]  rad_q;
    logic [HW+2:0] rem_q, cur, trial;
    logic [HW-1:0] root_q;
    logic [CW-1:0] cnt_q;

    assign cur   = {rem_q[HW:0], rad_q[W-1:W-2]};
    assign trial = {1'b0, root_q, 2'b01};
    assign root  = root_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rad_q <= '0; rem_q <= '0; root_q <= '0; cnt_q <= '0;
            busy  <= 1'b0; valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (start && !busy) begin
                rad_q  <= radicand;
                rem_q  <= '0;
                root_q <= '0;
                cnt_q  <= CW'(HW);
                busy   <= 1'b1;
            end else if (busy) begin
                if (cur >= trial) begin
                    rem_q  <= cur - trial;
                    root_q <= {root_q[HW-2:0], 1'b1};
                end else begin
                    rem_q  <= cur;
                    root_q <= {root_q[HW-2:0], 1'b0};
                end
                rad_q <= {rad_q[W-3:0], 2'b00};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy  <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end

    p_sqrt_start_idle_r6: assert property (@(posedge clk) disable iff (rst) start |-> !busy);
endmodule

// File: rtl/ast_compare.sv
module ast_compare #(
    parameter int W = 18
) (
    input  logic [W-1:0] expect_val,
    input  logic [W-1:0] actual_val,
    output logic         differ
);
    always_comb differ = |(expect_val ^ actual_val);
endmodule

// File: rtl/arith_selftest_slice.sv
module arith_selftest_slice
    import ast_pkg::*;
#(
    parameter logic [OPW-1:0] OPND_A = 18'd1000,
    parameter logic [OPW-1:0] OPND_B = 18'd7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OPS-1:0] inject_err,
    output logic [NUM_OPS-1:0] op_done,
    output logic [NUM_OPS-1:0] op_error,
    output logic               chk_disagree
);
    localparam int NUM_CHK = 2;

    op_e              op_q;
    ctl_e             st_q;
    logic [OPW-1:0]   res_q, alu_val, inj_mask;
    logic [2*OPW-1:0] prod;
    logic [OPW-1:0]   exp_tab [NUM_OPS];
    logic [NUM_CHK-1:0] miss;
    unit_res_t        div_res, sqrt_res;
    logic [HALFW-1:0] sqrt_root;
    logic             div_busy, sqrt_busy, div_go, sqrt_go;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_exp
        assign exp_tab[g] = golden(op_e'(g), OPND_A, OPND_B);
    end

    assign prod     = {{OPW{1'b0}}, OPND_A} * {{OPW{1'b0}}, OPND_B};
    assign inj_mask = {{(OPW-1){1'b0}}, inject_err[op_q]};
    assign div_go   = (st_q == ST_LAUNCH) && (op_q == OP_DIV);
    assign sqrt_go  = (st_q == ST_LAUNCH) && (op_q == OP_SQRT);

    always_comb begin
        case (op_q)
            OP_ADD:  alu_val = OPND_A + OPND_B;
            OP_SUB:  alu_val = OPND_A - OPND_B;
            OP_MUL:  alu_val = prod[OPW-1:0];
            default: alu_val = '0;
        endcase
    end

    ast_divider #(.W(OPW)) u_div (
        .clk(clk), .rst(rst), .start(div_go), .dividend(OPND_A), .divisor(OPND_B),
        .quotient(div_res.value), .busy(div_busy), .valid(div_res.valid)
    );

    ast_sqrt #(.W(OPW)) u_sqrt (
        .clk(clk), .rst(rst), .start(sqrt_go), .radicand(OPND_A),
        .root(sqrt_root), .busy(sqrt_busy), .valid(sqrt_res.valid)
    );
    assign sqrt_res.value = {{(OPW-HALFW){1'b0}}, sqrt_root};

    for (genvar c = 0; c < NUM_CHK; c++) begin : g_chk
        ast_compare #(.W(OPW)) u_cmp (
            .expect_val(exp_tab[op_q]), .actual_val(res_q), .differ(miss[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_LAUNCH; op_q <= OP_ADD; res_q <= '0;
            op_done <= '0; op_error <= '0; chk_disagree <= 1'b0;
        end else begin
            case (st_q)
                ST_LAUNCH: begin
                    if (op_q == OP_DIV || op_q == OP_SQRT) begin
                        st_q <= ST_WAIT;
                    end else begin
                        res_q <= alu_val ^ inj_mask;
                        st_q  <= ST_CHECK;
                    end
                end
                ST_WAIT: begin
                    if (op_q == OP_DIV && div_res.valid) begin
                        res_q <= div_res.value ^ inj_mask;
                        st_q  <= ST_CHECK;
                    end else if (op_q == OP_SQRT && sqrt_res.valid) begin
                        res_q <= sqrt_res.value ^ inj_mask;
                        st_q  <= ST_CHECK;
                    end
                end
                default: begin
                    op_done[op_q] <= 1'b1;
                    if (miss[0]) op_error[op_q] <= 1'b1;
                    if (miss[0] != miss[1]) chk_disagree <= 1'b1;
                    op_q <= (op_q == OP_SQRT) ? OP_ADD : op_e'(op_q + 3'd1);
                    st_q <= ST_LAUNCH;
                end
            endcase
        end
    end

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_prop
        p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst) op_done[i] |=> op_done[i]);
        p_err_sticky_r8:  assert property (@(posedge clk) disable iff (rst) op_error[i] |=> op_error[i]);
        p_err_has_done_r8: assert property (@(posedge clk) disable iff (rst) op_error[i] |-> op_done[i]);
        if (i > 0) begin : g_ord
            p_done_order_r7: assert property (@(posedge clk) disable iff (rst)
                $rose(op_done[i]) |-> op_done[i-1]);
        end
    end
    p_chk_agree_r9: assert property (@(posedge clk) disable iff (rst) !chk_disagree);
    p_wait_unit_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && op_q == OP_DIV) |-> (div_busy || div_res.valid));
    p_wait_unit_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && op_q == OP_SQRT) |-> (sqrt_busy || sqrt_res.valid));
endmodule

// File: tb/arith_selftest_slice_bench.sv
module arith_selftest_slice_bench;
    localparam int NV = 5;
    localparam int NO = 5;
    // operand pairs: mid-range, adder wrap, zero dividend, zero divisor, full scale
    localparam logic [17:0] TA [NV] = '{18'd1000, 18'h3FFFF, 18'd0,  18'd12345, 18'h3FFFF};
    localparam logic [17:0] TB [NV] = '{18'd7,    18'd1,     18'd5,  18'd0,     18'h3FFFF};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NO-1:0] inj [NV];
    logic [NO-1:0] done_v [NV];
    logic [NO-1:0] err_v [NV];
    logic          dis_v [NV];
    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    for (genvar g = 0; g < NV; g++) begin : g_dut
        arith_selftest_slice #(.OPND_A(TA[g]), .OPND_B(TB[g])) u_arith_selftest_slice (
            .clk(clk), .rst(rst), .inject_err(inj[g]),
            .op_done(done_v[g]), .op_error(err_v[g]), .chk_disagree(dis_v[g])
        );
    end

    task automatic chk(input string req, input int inst, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s inst %0d: actual %0h expected %0h", req, inst, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic string op_req(input int op);
        case (op)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        for (int v = 0; v < NV; v++) inj[v] = '0;
        wait_cyc(3);
        for (int v = 0; v < NV; v++) begin
            chk("R1 done in reset", v, 32'(done_v[v]), 0);
            chk("R1 error in reset", v, 32'(err_v[v]), 0);
        end
        rst = 1'b0;
        wait_cyc(1);
        for (int v = 0; v < NV; v++)
            chk("R1 done after release", v, 32'(done_v[v]), 0);
        wait_cyc(200);
        for (int v = 0; v < NV; v++) begin
            chk("R7 all done", v, 32'(done_v[v]), 32'h1F);
            for (int op = 0; op < NO; op++)
                chk(op_req(op), v, 32'(err_v[v][op]), 0);
            chk("R9 agree", v, 32'(dis_v[v]), 0);
        end
        // R10 / R8: late injection on multiply of instance 0
        inj[0] = 5'b00100;
        wait_cyc(100);
        chk("R8 R10 injected mul error", 0, 32'(err_v[0]), 32'h04);
        chk("R8 neighbour untouched", 1, 32'(err_v[1]), 0);
        chk("R9 agree under inject", 0, 32'(dis_v[0]), 0);
        inj[0] = '0;
        wait_cyc(100);
        chk("R8 error sticky", 0, 32'(err_v[0]), 32'h04);
        // divide path injection on instance 3 (zero divisor)
        inj[3] = 5'b01000;
        wait_cyc(100);
        inj[3] = '0;
        chk("R8 R5 div inject", 3, 32'(err_v[3]), 32'h08);
        rst = 1'b1;
        wait_cyc(2);
        for (int v = 0; v < NV; v++) begin
            chk("R1 flags cleared", v, 32'(err_v[v]), 0);
            chk("R1 done cleared", v, 32'(done_v[v]), 0);
            chk("R1 disagree cleared", v, 32'(dis_v[v]), 0);
        end
        rst = 1'b0;
        wait_cyc(200);
        chk("R7 done again", 4, 32'(done_v[4]), 32'h1F);
        chk("R6 sqrt full scale", 4, 32'(err_v[4]), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule